// File: doc/BRIEF.md
# Shared Tagged Receive Silo

This block gathers receive traffic from up to eight serial lines into one shared first-in first-out store. Two kinds of event arrive from the lines: a finished character (with parity and framing error flags from the line's receiver) and a carrier change (which counts only while that line's modem interrupt enable is set). Each event becomes one 15-bit tagged entry. The tag names the source line and holds the error flags. A carrier change becomes a special data-set-change entry with a zero character.

The host side sees one 16-bit read word. Bit 15 tells whether an entry is present. A read strobe pops the head entry. A write strobe on the same register loads the interrupt threshold and does not pop anything. Each line holds its events in a one-deep pending stage. The block serves the pending events one per cycle under a fixed priority. A lost event, whether dropped at the pending stage or refused by a full store, is flagged on the next entry that the block stores.

Top module: `rxsilo_top`

## Requirements
- R1: While the silo is empty, `readWord` is 16'h0000. A read strobe on an empty silo changes nothing.
- R2: A stored entry reads as: bit 15 = 1 (valid), bit 14 overrun, bit 13 framing error, bit 12 parity error, bit 11 data-set change, bits 10:8 source line, bits 7:0 character. Entries read back in the order they were stored.
- R3: A read strobe on a non-empty silo removes the head entry. From the next cycle, `readWord` shows the following entry, or 0 if none remains.
- R4: A carrier-change pulse on a line whose `modemIntEn` bit is set stores an entry with bit 11 set, that line's number, and bits 14:12 and 7:0 clear (apart from overrun). A pulse on a line whose enable is clear stores nothing.
- R5: The block stores at most one entry per cycle. The lowest-numbered line with something pending goes first. Within one line, a pending carrier change goes before a pending character. Other pending events wait.
- R6: A character strobe on a line whose previous character is still pending, and is not being stored in that cycle, is dropped. The drop counts as a lost event.
- R7: The silo holds 64 entries. An event served while 64 entries are stored is lost, even if a read happens in the same cycle.
- R8: After any lost event, the next entry stored has bit 14 set. Entries stored after that one have bit 14 clear, unless a further event is lost.
- R9: A write strobe loads the threshold from `hostWdata[6:0]` and does not pop the silo. The threshold resets to 1, and a threshold of 0 acts as 1.
- R10: `rxIrq` is high exactly when `rxIntEn` is high and the number of stored entries is at least the effective threshold.
- R11: After reset the silo is empty, nothing is pending, the overrun mark is clear and `rxIrq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| charStrobe | input | 8 | Per-line pulse: a character has been received |
| charData | input | 64 | Per-line character, line n in bits 8n+7:8n |
| parityErr | input | 8 | Per-line parity error flag, valid with the strobe |
| frameErr | input | 8 | Per-line framing error (break) flag, valid with the strobe |
| carrierChg | input | 8 | Per-line pulse: carrier detect changed |
| modemIntEn | input | 8 | Per-line enable for carrier-change entries |
| rxIntEn | input | 1 | Receive interrupt enable |
| hostRead | input | 1 | Read strobe on the receive word (pops the head) |
| hostWrite | input | 1 | Write strobe on the same register (loads the threshold) |
| hostWdata | input | 16 | Write data; bits 6:0 are the threshold |
| readWord | output | 16 | Head entry with the valid bit, or 0 when empty |
| rxIrq | output | 1 | Receive interrupt request |

## Verification
A wrong arbitration choice or a wrong pending-slot update appears at the ports as a misordered or mistagged line field. This shows two cycles after the strobes, once the entries are read out. An occupancy count out of step with the store appears in `rxIrq` in the same cycle. It also appears in the valid bit when the store drains, at the latest after 64 reads. A stale or lost overrun mark is visible only on bit 14 of the first entry stored after a loss. For that reason the stimulus deliberately overfills the store and causes drops at the pending stage.

// File: rtl/rxsilo_pkg.sv
package rxsilo_pkg;
  localparam int LINE_W = 3;
  localparam int CHAR_W = 8;

  typedef struct packed {
    logic              overrun;
    logic              frameErr;
    logic              parityErr;
    logic              dataSetChg;
    logic [LINE_W-1:0] line;
    logic [CHAR_W-1:0] ch;
  } silo_entry_t;

  typedef struct packed {
    logic        push;
    logic        pop;
    silo_entry_t wrEntry;
  } silo_strobe_t;
endpackage

// File: rtl/rxsilo_ctrl.sv
module rxsilo_ctrl
  import rxsilo_pkg::*;
#(
  parameter int DEPTH  = 64,
  parameter int NLINES = 8,
  parameter int THR_W  = 7,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [NLINES-1:0]        charStrobe,
  input  logic [NLINES*CHAR_W-1:0] charData,
  input  logic [NLINES-1:0]        parityErr,
  input  logic [NLINES-1:0]        frameErr,
  input  logic [NLINES-1:0]        carrierChg,
  input  logic [NLINES-1:0]        modemIntEn,
  input  logic                     rxIntEn,
  input  logic                     hostRead,
  input  logic                     hostWrite,
  input  logic [15:0]              hostWdata,
  output silo_strobe_t             strobes,
  output logic [CNT_W-1:0]         count,
  output logic                     rxIrq
);
  logic [NLINES-1:0] pendChar, pendDsc, pendPar, pendFrm;
  logic [CHAR_W-1:0] pendData [NLINES];
  logic [NLINES-1:0] grantChar, grantDsc, charDropVec;
  logic              anyReq, grantIsDsc, store, lostPush, lostAny, ovrFlag;
  logic [LINE_W-1:0] grantLine;
  logic [THR_W-1:0]  thr;
  logic [THR_W:0]    effThr;

  // fixed priority: lowest line number wins
  always_comb begin
    anyReq    = 1'b0;
    grantLine = '0;
    for (int i = NLINES - 1; i >= 0; i--) begin
      if (pendChar[i] || pendDsc[i]) begin
        anyReq    = 1'b1;
        grantLine = LINE_W'(i);
      end
    end
    grantIsDsc = anyReq && pendDsc[grantLine];
  end

  for (genvar i = 0; i < NLINES; i++) begin : g_line
    assign grantDsc[i]    = anyReq && (grantLine == LINE_W'(i)) && grantIsDsc;
    assign grantChar[i]   = anyReq && (grantLine == LINE_W'(i)) && !grantIsDsc;
    assign charDropVec[i] = charStrobe[i] && pendChar[i] && !grantChar[i];
  end

  assign store    = anyReq && (count < CNT_W'(DEPTH));
  assign lostPush = anyReq && !store;
  assign lostAny  = lostPush || (|charDropVec);

  always_comb begin
    strobes                    = '0;
    strobes.push               = store;
    strobes.pop                = hostRead && (count != '0);
    strobes.wrEntry.overrun    = ovrFlag;
    strobes.wrEntry.dataSetChg = grantIsDsc;
    strobes.wrEntry.line       = grantLine;
    if (!grantIsDsc) begin
      strobes.wrEntry.frameErr  = pendFrm[grantLine];
      strobes.wrEntry.parityErr = pendPar[grantLine];
      strobes.wrEntry.ch        = pendData[grantLine];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendChar <= '0;
      pendDsc  <= '0;
      pendPar  <= '0;
      pendFrm  <= '0;
      for (int i = 0; i < NLINES; i++) pendData[i] <= '0;
    end else begin
      for (int i = 0; i < NLINES; i++) begin
        if (charStrobe[i] && (!pendChar[i] || grantChar[i])) begin
          pendChar[i] <= 1'b1;
          pendData[i] <= charData[i*CHAR_W +: CHAR_W];
          pendPar[i]  <= parityErr[i];
          pendFrm[i]  <= frameErr[i];
        end else if (grantChar[i]) begin
          pendChar[i] <= 1'b0;
        end
        if (carrierChg[i] && modemIntEn[i]) pendDsc[i] <= 1'b1;
        else if (grantDsc[i])               pendDsc[i] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count   <= '0;
      ovrFlag <= 1'b0;
      thr     <= THR_W'(1);
    end else begin
      count   <= count + CNT_W'(store) - CNT_W'(strobes.pop);
      ovrFlag <= lostAny || (ovrFlag && !store);
      if (hostWrite) thr <= hostWdata[THR_W-1:0];
    end
  end

  assign effThr = (thr == '0) ? (THR_W+1)'(1) : {1'b0, thr};
  assign rxIrq  = rxIntEn && ((THR_W+1)'(count) >= effThr);

  a_r7_count_bound: assert property (@(posedge clk) disable iff (!rstN)
    count <= CNT_W'(DEPTH));
  a_r7_no_push_full: assert property (@(posedge clk) disable iff (!rstN)
    (count == CNT_W'(DEPTH)) |-> !strobes.push);
  a_r3_pop_decrements: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.pop && !strobes.push) |=> (count == $past(count) - CNT_W'(1)));
  a_r10_irq_nonempty: assert property (@(posedge clk) disable iff (!rstN)
    rxIrq |-> (count != '0));
  a_r8_overrun_once: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.push && !lostAny) |=> !ovrFlag);
  a_r5_single_grant: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(grantChar | grantDsc));
endmodule

// File: rtl/rxsilo_data.sv
module rxsilo_data
  import rxsilo_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic         clk,
  input  logic         rstN,
  input  silo_strobe_t strobes,
  output silo_entry_t  headEntry
);
  silo_entry_t    mem [DEPTH];
  logic [AW-1:0]  wrPtr, rdPtr;

  always_ff @(posedge clk) begin
    if (strobes.push) mem[wrPtr] <= strobes.wrEntry;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      if (strobes.push) wrPtr <= wrPtr + AW'(1);
      if (strobes.pop)  rdPtr <= rdPtr + AW'(1);
    end
  end

  assign headEntry = mem[rdPtr];
endmodule

// File: rtl/rxsilo_top.sv
module rxsilo_top
  import rxsilo_pkg::*;
#(
  parameter int DEPTH  = 64,
  parameter int NLINES = 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [NLINES-1:0]        charStrobe,
  input  logic [NLINES*CHAR_W-1:0] charData,
  input  logic [NLINES-1:0]        parityErr,
  input  logic [NLINES-1:0]        frameErr,
  input  logic [NLINES-1:0]        carrierChg,
  input  logic [NLINES-1:0]        modemIntEn,
  input  logic                     rxIntEn,
  input  logic                     hostRead,
  input  logic                     hostWrite,
  input  logic [15:0]              hostWdata,
  output logic [15:0]              readWord,
  output logic                     rxIrq
);
  silo_strobe_t     strobes;
  silo_entry_t      headEntry;
  logic [CNT_W-1:0] count;

  rxsilo_ctrl #(.DEPTH(DEPTH), .NLINES(NLINES)) u_ctrl (
    .clk(clk), .rstN(rstN), .charStrobe(charStrobe), .charData(charData),
    .parityErr(parityErr), .frameErr(frameErr), .carrierChg(carrierChg),
    .modemIntEn(modemIntEn), .rxIntEn(rxIntEn), .hostRead(hostRead),
    .hostWrite(hostWrite), .hostWdata(hostWdata), .strobes(strobes),
    .count(count), .rxIrq(rxIrq)
  );

  rxsilo_data #(.DEPTH(DEPTH)) u_data (
    .clk(clk), .rstN(rstN), .strobes(strobes), .headEntry(headEntry)
  );

  assign readWord = (count != '0) ? {1'b1, headEntry} : 16'h0000;

  a_r1_valid_tracks_push: assert property (@(posedge clk) disable iff (!rstN)
    strobes.push |=> readWord[15]);
endmodule

// File: tb/sim_rxsilo_top.sv
`timescale 1ns/1ps
module sim_rxsilo_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  charStrobe = '0, parityErr = '0, frameErr = '0;
  logic [7:0]  carrierChg = '0, modemIntEn = '0;
  logic [63:0] charData = '0;
  logic        rxIntEn = 1'b0, hostRead = 1'b0, hostWrite = 1'b0;
  logic [15:0] hostWdata = '0;
  logic [15:0] readWord;
  logic        rxIrq;

  int checks = 0, errors = 0;
  bit done = 0;

  // requirement model state
  logic [14:0] mq[$];
  bit          mPendC[8], mPendD[8], mPar[8], mFrm[8];
  logic [7:0]  mData[8];
  bit          mOvr;
  logic [6:0]  mThr;

  always #2.5 clk = ~clk;

  rxsilo_top u0 (
    .clk(clk), .rstN(rstN), .charStrobe(charStrobe), .charData(charData),
    .parityErr(parityErr), .frameErr(frameErr), .carrierChg(carrierChg),
    .modemIntEn(modemIntEn), .rxIntEn(rxIntEn), .hostRead(hostRead),
    .hostWrite(hostWrite), .hostWdata(hostWdata), .readWord(readWord), .rxIrq(rxIrq)
  );

  function void modelReset();
    mq.delete();
    for (int i = 0; i < 8; i++) begin
      mPendC[i] = 0; mPendD[i] = 0; mPar[i] = 0; mFrm[i] = 0; mData[i] = '0;
    end
    mOvr = 0;
    mThr = 7'd1;
  endfunction

  function void modelStep();
    int g; bit any, gd, stored, drop;
    logic [14:0] e;
    any = 0; g = 0; e = '0;
    for (int i = 7; i >= 0; i--) if (mPendC[i] || mPendD[i]) begin any = 1; g = i; end
    gd = any && mPendD[g];
    stored = any && (mq.size() < 64);
    drop = any && !stored;
    if (any) e = {mOvr, gd ? 1'b0 : mFrm[g], gd ? 1'b0 : mPar[g], gd, 3'(g), gd ? 8'h00 : mData[g]};
    if (hostRead && mq.size() > 0) void'(mq.pop_front());
    if (stored) mq.push_back(e);
    if (any) begin
      if (gd) mPendD[g] = 0; else mPendC[g] = 0;
    end
    for (int i = 0; i < 8; i++) begin
      if (charStrobe[i]) begin
        if (mPendC[i]) drop = 1;
        else begin
          mPendC[i] = 1; mData[i] = charData[i*8 +: 8];
          mPar[i] = parityErr[i]; mFrm[i] = frameErr[i];
        end
      end
      if (carrierChg[i] && modemIntEn[i]) mPendD[i] = 1;
    end
    mOvr = drop || (mOvr && !stored);
    if (hostWrite) mThr = hostWdata[6:0];
  endfunction

  function logic [15:0] expWord();
    return (mq.size() > 0) ? {1'b1, mq[0]} : 16'h0000;
  endfunction

  function logic expIrq();
    int t;
    t = (mThr == 0) ? 1 : int'(mThr);
    return rxIntEn && (mq.size() >= t);
  endfunction

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic compareAll(string tag);
    chk({tag, " word"}, readWord, expWord());
    chk({tag, " irq"}, {15'd0, rxIrq}, {15'd0, expIrq()});
  endtask

  // inputs are set at a falling edge; this applies them for one rising edge
  task automatic step(string tag);
    modelStep();
    @(posedge clk);
    @(negedge clk);
    charStrobe = '0; carrierChg = '0; hostRead = 1'b0; hostWrite = 1'b0;
    compareAll(tag);
  endtask

  task automatic putChar(int ln, logic [7:0] d, bit p, bit f);
    charStrobe[ln] = 1'b1;
    charData[ln*8 +: 8] = d;
    parityErr[ln] = p;
    frameErr[ln] = f;
  endtask

  task automatic drain(string tag);
    while (mq.size() > 0) begin
      hostRead = 1'b1;
      step(tag);
    end
    step(tag);
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int reads;
    void'($urandom(32'd20240611));
    modelReset();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    compareAll("R11 reset");
    chk("R11 reset literal", readWord, 16'h0000);

    // R1: read while empty
    hostRead = 1'b1;
    step("R1");
    chk("R1 empty read", readWord, 16'h0000);

    // R2: one character with parity error on line 5
    putChar(5, 8'h41, 1'b1, 1'b0);
    step("R2");
    step("R2");
    chk("R2 format", readWord, 16'h9541);
    // R3: pop leaves the silo empty
    hostRead = 1'b1;
    step("R3");
    chk("R3 popped", readWord, 16'h0000);

    // R4: carrier change with and without its enable
    modemIntEn = 8'b0000_1000;
    carrierChg[3] = 1'b1;
    step("R4");
    step("R4");
    chk("R4 dsc entry", readWord, 16'h8B00);
    hostRead = 1'b1;
    step("R4");
    carrierChg[2] = 1'b1;
    step("R4");
    step("R4");
    chk("R4 disabled line ignored", readWord, 16'h0000);

    // R5: simultaneous requests, dsc first within a line
    modemIntEn = 8'hFF;
    putChar(6, 8'h66, 1'b0, 1'b0);
    putChar(1, 8'h11, 1'b0, 1'b1);
    putChar(4, 8'h44, 1'b0, 1'b0);
    carrierChg[1] = 1'b1;
    step("R5");
    repeat (4) step("R5");
    chk("R5 first is line 1 dsc", readWord, 16'h8900);
    drain("R5");

    // R6: second strobe on a line whose character is still waiting
    for (int i = 0; i < 8; i++) putChar(i, 8'(8'h30 + i), 1'b0, 1'b0);
    step("R6");
    putChar(7, 8'h99, 1'b0, 1'b0);
    step("R6");
    repeat (8) step("R6");
    drain("R6");

    // R7, R8: overfill the silo, then read everything back
    for (int k = 0; k < 10; k++) begin
      for (int i = 0; i < 8; i++) putChar(i, 8'(k * 8 + i), 1'b0, 1'b0);
      step("R7");
      repeat (7) step("R7");
    end
    repeat (2) step("R7");
    reads = 0;
    while (readWord[15]) begin
      reads++;
      hostRead = 1'b1;
      step("R8");
    end
    chk("R7 depth", 16'(reads), 16'd64);
    putChar(2, 8'h22, 1'b0, 1'b0);
    step("R8");
    step("R8");
    chk("R8 overrun on next stored", readWord, 16'hC222);
    drain("R8");

    // R9, R10: threshold and interrupt
    rxIntEn = 1'b1;
    hostWrite = 1'b1; hostWdata = 16'h0003;
    step("R9");
    for (int i = 0; i < 4; i++) begin
      putChar(i, 8'(i), 1'b0, 1'b0);
      step("R10");
      step("R10");
    end
    hostWrite = 1'b1; hostWdata = 16'h0000;
    step("R9");
    rxIntEn = 1'b0;
    step("R10");
    rxIntEn = 1'b1;
    drain("R10");

    // random mix
    for (int n = 0; n < 6000; n++) begin
      charStrobe = 8'($urandom & $urandom & $urandom);
      charData   = {$urandom, $urandom};
      parityErr  = 8'($urandom);
      frameErr   = 8'($urandom & $urandom);
      carrierChg = 8'($urandom & $urandom & $urandom & $urandom);
      if (($urandom % 16) == 0) modemIntEn = 8'($urandom);
      if (($urandom % 32) == 0) rxIntEn = 1'($urandom);
      hostRead = (n % 1000 < 300) ? 1'b0 : 1'($urandom);
      if (($urandom % 50) == 0) begin
        hostWrite = 1'b1;
        hostWdata = 16'($urandom % 20);
      end
      step("R5 random");
    end
    drain("R3 random");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule